// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block sits at the home memory node of a shared-memory multiprocessor and keeps a full-map record of which processors hold each memory block. For every block it stores one presence bit per processor and a three-valued state (Uncached, Shared, Exclusive). It also owns the backing data word of each block. Caches send it read misses, write misses and data write-backs. It answers with invalidations, owner recalls (fetch or fetch-and-invalidate) and data replies on a single message channel.

Requests are taken one at a time. Once a request is accepted, the request channel is closed until the transaction's final message has been produced. When a block is held exclusively, the controller sends a recall to the owner and waits for the owner's data on a separate return input. It writes that data into memory, and only then replies to the requester. Invalidations go out one per cycle, in ascending processor order, and always come before the reply.

Top module: `home_dir_ctrl`

## Requirements
- R1: After reset every block is Uncached with no sharers, the data word of block b holds the value b, req_ready is high and msg_valid is low.
- R2: A read miss to an Uncached or Shared block produces one reply (kind 4) to the requester carrying the block's memory word. The requester joins the sharers and the block becomes Shared.
- R3: A write miss to an Uncached block produces only a reply to the requester with the memory word. The block becomes Exclusive with the requester as its sole sharer.
- R4: A write miss to a Shared block sends an invalidate (kind 1) to every sharer except the requester, in ascending processor index, and then a reply. The requester becomes the sole owner in Exclusive.
- R5: A read miss to an Exclusive block sends a fetch (kind 2) to the owner and waits for fb_valid. It writes fb_data into memory and replies with it. The block becomes Shared with owner and requester as sharers.
- R6: A write miss to an Exclusive block sends a fetch-invalidate (kind 3) to the owner and waits for the returned data. It writes that data to memory and replies with it. The block stays Exclusive with the requester as sole owner.
- R7: A data write-back to an Exclusive block stores req_data into memory, empties the sharer set and makes the block Uncached. No message is produced.
- R8: A data write-back to a block that is not Exclusive changes neither memory nor directory state and produces no message.
- R9: req_ready is low from the cycle after a request is accepted until the transaction completes, so requests to any block stall. fb_valid has no effect outside the wait for recalled data.
- R10: Request kinds are encoded 0 read miss, 1 write miss, 2 write-back. Message kinds are encoded 1 invalidate, 2 fetch, 3 fetch-invalidate, 4 reply. msg_data is meaningful only in replies.
- R11: At most one message per cycle. No message appears that the transaction's rules do not call for, and every transaction that replies ends with exactly one reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 write-back |
| req_src | input | $clog2(NPROC) | Requesting processor |
| req_blk | input | $clog2(NBLK) | Block number |
| req_data | input | DW | Write-back data |
| fb_valid | input | 1 | Owner's recalled data present |
| fb_data | input | DW | Owner's recalled data |
| msg_valid | output | 1 | Outgoing message present |
| msg_kind | output | 3 | 1 invalidate, 2 fetch, 3 fetch-invalidate, 4 reply |
| msg_dst | output | $clog2(NPROC) | Destination processor |
| msg_blk | output | $clog2(NBLK) | Block the message concerns |
| msg_data | output | DW | Reply data, zero otherwise |

## Verification
The main function is tried with one block that is driven through all three states. It is first shared by three readers. A member of that group then writes, so the invalidate list must skip the requester and keep ascending order. A reader then recalls the line from the owner, and a second writer recalls it again, which separates fetch from fetch-invalidate. Write-backs are applied both to an owned block and to a merely shared one. Fresh blocks are read and written so that data can be told apart per block and a wrong address shows up. A stray fb_valid pulse while idle, and probes of req_ready during a recall wait, separate a controller that really waits from one that replies early.

// File: rtl/dir_pkg.sv
// Shared encodings for the home directory controller.
package dir_pkg;
    typedef enum logic [1:0] {
        REQ_RD = 2'd0,
        REQ_WR = 2'd1,
        REQ_WB = 2'd2
    } req_kind_e;

    typedef enum logic [2:0] {
        MSG_NONE     = 3'd0,
        MSG_INV      = 3'd1,
        MSG_FETCH    = 3'd2,
        MSG_FETCHINV = 3'd3,
        MSG_REPLY    = 3'd4
    } msg_kind_e;

    typedef enum logic [1:0] {
        BLK_UNC = 2'd0,
        BLK_SHR = 2'd1,
        BLK_EXC = 2'd2
    } blk_state_e;
endpackage

// File: rtl/dir_store.sv
// Directory entry array: one state and one presence vector per block.
// Assumes a single read and a single write address (the controller uses
// the same block for both). Reset leaves all blocks Uncached and empty.
module dir_store
    import dir_pkg::*;
#(
    parameter int NPROC = 4,
    parameter int NBLK  = 16,
    localparam int BW   = $clog2(NBLK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BW-1:0]    blk,
    output blk_state_e       rd_state,
    output logic [NPROC-1:0] rd_shr,
    input  logic             wr_en,
    input  blk_state_e       wr_state,
    input  logic [NPROC-1:0] wr_shr
);
    blk_state_e       st_q  [NBLK];
    logic [NPROC-1:0] shr_q [NBLK];

    // Entry update: reset everything, otherwise write the addressed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NBLK; b++) begin
                st_q[b]  <= BLK_UNC;
                shr_q[b] <= '0;
            end
        end else if (wr_en) begin
            st_q[blk]  <= wr_state;
            shr_q[blk] <= wr_shr;
        end
    end

    // Asynchronous read of the addressed entry.
    always_comb begin
        rd_state = st_q[blk];
        rd_shr   = shr_q[blk];
    end
endmodule

// File: rtl/dir_mem.sv
// Backing data store of the home node, one word per block.
// Assumes NBLK is a power of two. Reset loads word b with the value b.
module dir_mem #(
    parameter int NBLK = 16,
    parameter int DW   = 32,
    localparam int BW  = $clog2(NBLK)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [BW-1:0] blk,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem_q [NBLK];

    // Word update: reset to the block index, else write when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NBLK; b++) mem_q[b] <= DW'(b);
        end else if (wr_en) begin
            mem_q[blk] <= wr_data;
        end
    end

    // Asynchronous read port.
    assign rd_data = mem_q[blk];
endmodule

// File: rtl/dir_ctrl.sv
// Transaction sequencer of the home directory. It takes one request,
// looks up the entry, sends invalidates or a recall, waits for recalled
// data, replies and updates the entry. All messages are registered and
// there is one per cycle at most. It assumes the owner of an Exclusive
// block is the single set presence bit and that caches accept every message.
module dir_ctrl
    import dir_pkg::*;
#(
    parameter int NPROC = 4,
    parameter int NBLK  = 16,
    parameter int DW    = 32,
    localparam int PW   = $clog2(NPROC),
    localparam int BW   = $clog2(NBLK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_kind,
    input  logic [PW-1:0]    req_src,
    input  logic [BW-1:0]    req_blk,
    input  logic [DW-1:0]    req_data,
    input  logic             fb_valid,
    input  logic [DW-1:0]    fb_data,
    output logic [BW-1:0]    cur_blk,
    output logic [PW-1:0]    cur_src,
    input  blk_state_e       ent_state,
    input  logic [NPROC-1:0] ent_shr,
    output logic             dir_we,
    output blk_state_e       dir_wstate,
    output logic [NPROC-1:0] dir_wshr,
    output logic             mem_we,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    output logic             msg_valid,
    output logic [2:0]       msg_kind,
    output logic [PW-1:0]    msg_dst,
    output logic [BW-1:0]    msg_blk,
    output logic [DW-1:0]    msg_data
);
    localparam logic [PW-1:0] LAST = PW'(NPROC - 1);

    typedef enum logic [2:0] {S_IDLE, S_LOOK, S_INV, S_WAIT, S_REPLY} seq_e;

    seq_e             st_q, st_d;
    logic [PW-1:0]    idx_q, idx_d;
    req_kind_e        kind_q;
    logic [PW-1:0]    src_q;
    logic [BW-1:0]    blk_q;
    logic [DW-1:0]    data_q;
    logic             nv;
    msg_kind_e        nk;
    logic [PW-1:0]    nd;
    logic [DW-1:0]    ndata;
    logic [PW-1:0]    owner;
    logic [NPROC-1:0] src_bit;

    assign req_ready = (st_q == S_IDLE);
    assign cur_blk   = blk_q;
    assign cur_src   = src_q;

    // Owner of an Exclusive block: lowest set presence bit.
    always_comb begin
        owner = '0;
        for (int p = NPROC - 1; p >= 0; p--) begin
            if (ent_shr[p]) owner = PW'(p);
        end
    end

    // One-hot presence bit of the requester.
    always_comb begin
        src_bit         = '0;
        src_bit[src_q]  = 1'b1;
    end

    // Next-state, message and entry-update decisions.
    always_comb begin
        st_d       = st_q;
        idx_d      = idx_q;
        nv         = 1'b0;
        nk         = MSG_NONE;
        nd         = '0;
        ndata      = '0;
        dir_we     = 1'b0;
        dir_wstate = ent_state;
        dir_wshr   = ent_shr;
        mem_we     = 1'b0;
        mem_wdata  = data_q;
        case (st_q)
            S_IDLE: if (req_valid) st_d = S_LOOK;
            S_LOOK: begin
                case (kind_q)
                    REQ_WB: begin
                        if (ent_state == BLK_EXC) begin
                            mem_we     = 1'b1;
                            dir_we     = 1'b1;
                            dir_wstate = BLK_UNC;
                            dir_wshr   = '0;
                        end
                        st_d = S_IDLE;
                    end
                    REQ_RD: begin
                        if (ent_state == BLK_EXC) begin
                            nv   = 1'b1;
                            nk   = MSG_FETCH;
                            nd   = owner;
                            st_d = S_WAIT;
                        end else begin
                            st_d = S_REPLY;
                        end
                    end
                    REQ_WR: begin
                        if (ent_state == BLK_EXC) begin
                            nv   = 1'b1;
                            nk   = MSG_FETCHINV;
                            nd   = owner;
                            st_d = S_WAIT;
                        end else if (ent_state == BLK_SHR) begin
                            idx_d = '0;
                            st_d  = S_INV;
                        end else begin
                            st_d = S_REPLY;
                        end
                    end
                    default: st_d = S_IDLE;
                endcase
            end
            S_INV: begin
                if (ent_shr[idx_q] && idx_q != src_q) begin
                    nv = 1'b1;
                    nk = MSG_INV;
                    nd = idx_q;
                end
                if (idx_q == LAST) st_d = S_REPLY;
                else idx_d = idx_q + 1'b1;
            end
            S_WAIT: begin
                if (fb_valid) begin
                    mem_we    = 1'b1;
                    mem_wdata = fb_data;
                    st_d      = S_REPLY;
                end
            end
            S_REPLY: begin
                nv     = 1'b1;
                nk     = MSG_REPLY;
                nd     = src_q;
                ndata  = mem_rdata;
                dir_we = 1'b1;
                if (kind_q == REQ_WR) begin
                    dir_wstate = BLK_EXC;
                    dir_wshr   = src_bit;
                end else begin
                    dir_wstate = BLK_SHR;
                    dir_wshr   = ent_shr | src_bit;
                end
                st_d = S_IDLE;
            end
            default: st_d = S_IDLE;
        endcase
    end

    // Sequencer state and request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            idx_q  <= '0;
            kind_q <= REQ_RD;
            src_q  <= '0;
            blk_q  <= '0;
            data_q <= '0;
        end else begin
            st_q  <= st_d;
            idx_q <= idx_d;
            if (st_q == S_IDLE && req_valid) begin
                kind_q <= req_kind_e'(req_kind);
                src_q  <= req_src;
                blk_q  <= req_blk;
                data_q <= req_data;
            end
        end
    end

    // Registered message output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid <= 1'b0;
            msg_kind  <= MSG_NONE;
            msg_dst   <= '0;
            msg_blk   <= '0;
            msg_data  <= '0;
        end else begin
            msg_valid <= nv;
            msg_kind  <= nk;
            msg_dst   <= nd;
            msg_blk   <= blk_q;
            msg_data  <= ndata;
        end
    end
endmodule

// File: rtl/home_dir_ctrl.sv
// Home node directory controller top: sequencer, directory entries and
// backing data words. It services one transaction at a time. Its request
// port holds only while req_ready is high, and every message is accepted.
module home_dir_ctrl
    import dir_pkg::*;
#(
    parameter int NPROC = 4,
    parameter int NBLK  = 16,
    parameter int DW    = 32,
    localparam int PW   = $clog2(NPROC),
    localparam int BW   = $clog2(NBLK)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_kind,
    input  logic [PW-1:0] req_src,
    input  logic [BW-1:0] req_blk,
    input  logic [DW-1:0] req_data,
    input  logic          fb_valid,
    input  logic [DW-1:0] fb_data,
    output logic          msg_valid,
    output logic [2:0]    msg_kind,
    output logic [PW-1:0] msg_dst,
    output logic [BW-1:0] msg_blk,
    output logic [DW-1:0] msg_data
);
    logic [BW-1:0]    cur_blk;
    logic [PW-1:0]    cur_src;
    blk_state_e       ent_state;
    logic [NPROC-1:0] ent_shr;
    logic             dir_we;
    blk_state_e       dir_wstate;
    logic [NPROC-1:0] dir_wshr;
    logic             mem_we;
    logic [DW-1:0]    mem_wdata;
    logic [DW-1:0]    mem_rdata;

    dir_ctrl #(.NPROC(NPROC), .NBLK(NBLK), .DW(DW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_src(req_src), .req_blk(req_blk), .req_data(req_data),
        .fb_valid(fb_valid), .fb_data(fb_data),
        .cur_blk(cur_blk), .cur_src(cur_src),
        .ent_state(ent_state), .ent_shr(ent_shr),
        .dir_we(dir_we), .dir_wstate(dir_wstate), .dir_wshr(dir_wshr),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_dst(msg_dst),
        .msg_blk(msg_blk), .msg_data(msg_data)
    );

    dir_store #(.NPROC(NPROC), .NBLK(NBLK)) u_store (
        .clk(clk), .rst_n(rst_n), .blk(cur_blk),
        .rd_state(ent_state), .rd_shr(ent_shr),
        .wr_en(dir_we), .wr_state(dir_wstate), .wr_shr(dir_wshr)
    );

    dir_mem #(.NBLK(NBLK), .DW(DW)) u_mem (
        .clk(clk), .rst_n(rst_n), .blk(cur_blk),
        .wr_en(mem_we), .wr_data(mem_wdata), .rd_data(mem_rdata)
    );
endmodule

// File: rtl/dir_chk.sv
// Protocol checker for the home directory controller, bound to the top.
module dir_chk #(
    parameter int PW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          msg_valid,
    input logic [2:0]    msg_kind,
    input logic [PW-1:0] msg_dst,
    input logic [PW-1:0] cur_src
);
    // R4: the requester never receives an invalidate for its own request.
    assert_no_self_inv_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == 3'd1) |-> (msg_dst != cur_src));

    // R2: replies go to the processor whose request is being serviced.
    assert_reply_dst_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == 3'd4) |-> (msg_dst == cur_src));

    // R9: accepting a request closes the request channel next cycle.
    assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R10: only the four defined message kinds appear.
    assert_kind_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_kind >= 3'd1 && msg_kind <= 3'd4));

    // R5: a recall is outstanding while the fetch is visible.
    assert_fetch_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && (msg_kind == 3'd2 || msg_kind == 3'd3)) |-> !req_ready);

    // R11: the reply is the last message of its transaction.
    assert_reply_last_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == 3'd4) |-> req_ready);
endmodule

bind home_dir_ctrl dir_chk #(.PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_dst(msg_dst),
    .cur_src(cur_src)
);

// File: tb/sim_home_dir_ctrl.sv
`timescale 1ns/1ps
module sim_home_dir_ctrl;
    localparam int NPROC = 4;
    localparam int NBLK  = 16;
    localparam int DW    = 32;
    localparam int PW    = $clog2(NPROC);
    localparam int BW    = $clog2(NBLK);

    localparam int K_INV = 1, K_FET = 2, K_FIN = 3, K_REP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_kind = '0;
    logic [PW-1:0] req_src = '0;
    logic [BW-1:0] req_blk = '0;
    logic [DW-1:0] req_data = '0;
    logic          fb_valid = 1'b0;
    logic [DW-1:0] fb_data = '0;
    logic          msg_valid;
    logic [2:0]    msg_kind;
    logic [PW-1:0] msg_dst;
    logic [BW-1:0] msg_blk;
    logic [DW-1:0] msg_data;

    home_dir_ctrl #(.NPROC(NPROC), .NBLK(NBLK), .DW(DW)) u0 (.*);

    always #4 clk = ~clk;

    typedef struct {
        int            kind;
        int            dst;
        int            blk;
        logic [DW-1:0] data;
        string         tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    int   cyc = 0;
    bit   done = 1'b0;

    task automatic check(bit ok, string tag, string what, logic [DW-1:0] act, logic [DW-1:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic expect_msg(int kind, int dst, int blk, logic [DW-1:0] data, string tag);
        exp_t e;
        e.kind = kind; e.dst = dst; e.blk = blk; e.data = data; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compare every message against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && msg_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R11", "unexpected message kind", DW'(msg_kind), '0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(msg_kind == 3'(e.kind) && msg_dst == PW'(e.dst) && msg_blk == BW'(e.blk)
                      && (e.kind != K_REP || msg_data == e.data),
                      e.tag, "message kind/dst/blk/data",
                      {DW'(msg_kind) << 28} | {DW'(msg_dst) << 24} | DW'(msg_data[15:0]),
                      {DW'(e.kind) << 28} | {DW'(e.dst) << 24} | DW'(e.data[15:0]));
            end
        end
    end

    task automatic send(int kind, int src, int blk, logic [DW-1:0] data);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_kind  = 2'(kind);
        req_src   = PW'(src);
        req_blk   = BW'(blk);
        req_data  = data;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Return recalled data after confirming the controller is stalled.
    task automatic give_back(logic [DW-1:0] data, string tag);
        repeat (3) @(negedge clk);
        check(req_ready == 1'b0, tag, "req_ready during recall wait", DW'(req_ready), '0);
        fb_valid = 1'b1;
        fb_data  = data;
        @(negedge clk);
        fb_valid = 1'b0;
    endtask

    task automatic settle();
        while (!req_ready) @(negedge clk);
        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "R11", "outstanding expected messages", DW'(sb_q.size()), '0);
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL R11 watchdog expired actual=%0d expected=%0d", cyc, 20000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        check(req_ready == 1'b1, "R1", "req_ready after reset", DW'(req_ready), 1);
        check(msg_valid == 1'b0, "R1", "msg_valid after reset", DW'(msg_valid), 0);

        // R9: stray recalled data while idle must not disturb memory
        fb_valid = 1'b1; fb_data = 32'hDEAD_BEEF;
        @(negedge clk);
        fb_valid = 1'b0;

        // R1 R2: three readers of block 3 get its reset word
        expect_msg(K_REP, 1, 3, 32'd3, "R2");
        send(0, 1, 3, '0); settle();
        expect_msg(K_REP, 2, 3, 32'd3, "R2");
        send(0, 2, 3, '0); settle();
        expect_msg(K_REP, 0, 3, 32'd3, "R1");
        send(0, 0, 3, '0); settle();

        // R4: sharer P1 writes; P0 and P2 invalidated in order, not P1
        expect_msg(K_INV, 0, 3, '0, "R4");
        expect_msg(K_INV, 2, 3, '0, "R4");
        expect_msg(K_REP, 1, 3, 32'd3, "R4");
        send(1, 1, 3, '0); settle();

        // R5: P3 reads owned block; fetch to P1, reply with recalled data
        expect_msg(K_FET, 1, 3, '0, "R5");
        expect_msg(K_REP, 3, 3, 32'hAAAA_0001, "R5");
        send(0, 3, 3, '0); give_back(32'hAAAA_0001, "R9"); settle();

        // R5 R4: owner kept a shared copy: P0 write invalidates P1 and P3
        expect_msg(K_INV, 1, 3, '0, "R5");
        expect_msg(K_INV, 3, 3, '0, "R4");
        expect_msg(K_REP, 0, 3, 32'hAAAA_0001, "R5");
        send(1, 0, 3, '0); settle();

        // R6: P2 writes owned block; fetch-invalidate to P0
        expect_msg(K_FIN, 0, 3, '0, "R6");
        expect_msg(K_REP, 2, 3, 32'hBBBB_0002, "R6");
        send(1, 2, 3, '0); give_back(32'hBBBB_0002, "R6"); settle();

        // R7: owner writes back silently; next read sees the data, no fetch
        send(2, 2, 3, 32'hCCCC_0003); settle();
        expect_msg(K_REP, 0, 3, 32'hCCCC_0003, "R7");
        send(0, 0, 3, '0); settle();

        // R8: write-back to a Shared block is ignored
        send(2, 1, 3, 32'h1111_1111); settle();
        expect_msg(K_INV, 0, 3, '0, "R8");
        expect_msg(K_REP, 1, 3, 32'hCCCC_0003, "R8");
        send(1, 1, 3, '0); settle();

        // R3: write miss to fresh block 7, then recall from P3
        expect_msg(K_REP, 3, 7, 32'd7, "R3");
        send(1, 3, 7, '0); settle();
        expect_msg(K_FET, 3, 7, '0, "R3");
        expect_msg(K_REP, 0, 7, 32'h0000_0077, "R5");
        send(0, 0, 7, '0); give_back(32'h0000_0077, "R9"); settle();

        // R7 R3: block 15 written, written back, then uncached write again
        expect_msg(K_REP, 2, 15, 32'd15, "R3");
        send(1, 2, 15, '0); settle();
        send(2, 2, 15, 32'h0000_0055); settle();
        expect_msg(K_REP, 1, 15, 32'h0000_0055, "R7");
        send(1, 1, 15, '0); settle();

        // R8: write-back to an Uncached block leaves memory unchanged
        send(2, 0, 9, 32'h9999_9999); settle();
        expect_msg(K_REP, 0, 9, 32'd9, "R8");
        send(0, 0, 9, '0); settle();

        // R10: request kind 3 is not a request: no message
        send(3, 0, 9, '0); settle();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule